// File: doc/BRIEF.md
# Single-Cycle Integer Core (Six-Instruction Subset)

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction on every rising clock edge. It carries a byte-addressed program counter, a 32 x 32 register file with two combinational operand ports, an immediate extender, a three-function ALU with a zero flag, next-address logic and a main decoder. Instruction and data storage are small internal word arrays.

While reset is held, a test harness fills both arrays through a preload port. After reset is released the core runs the stored program. Its registers and data words can be read at any time through a debug port, and such reads do not change what the core does. Any encoding outside the six supported instructions retires as a no-op that only moves the PC on by four.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and clears every register, and a store during reset does not change data memory.
- R2: Opcode 0x00 with shamt (bits 10:6) zero selects by funct (bits 5:0). Funct 0x21 writes R[rs]+R[rt] into R[rd] and funct 0x23 writes R[rs]-R[rt] into R[rd], both modulo 2^32 and without a trap. The fields are rs in bits 25:21, rt in 20:16 and rd in 15:11.
- R3: Opcode 0x0D (bits 31:26) writes R[rs] OR the zero-extended bits 15:0 into R[rt].
- R4: Opcode 0x23 loads R[rt] from the data word at byte address R[rs] + sign-extended bits 15:0. The address is word-indexed by its bits above bit 1.
- R5: Opcode 0x2B writes R[rt] to the data word at that same computed address on the clock edge. No other instruction changes data memory.
- R6: Opcode 0x04 with R[rs] equal to R[rt] sets the next PC to PC+4 plus the sign-extended immediate shifted left by two.
- R7: Opcode 0x04 with unequal operands, and every other instruction, sets the next PC to PC+4.
- R8: Register 0 always reads as zero, and writes aimed at it are discarded.
- R9: An unknown opcode, an R-type with an unknown funct, or an R-type with nonzero shamt changes no register and no memory word.
- R10: The preload port writes a word in either array on the clock edge, and a preload write to data memory wins over a core store in the same cycle. Debug reads of a register or a data word are combinational and do not disturb the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_imem_we | input | 1 | Preload write strobe for instruction memory |
| ld_dmem_we | input | 1 | Preload write strobe for data memory |
| ld_addr | input | 6 | Word index for a preload write |
| ld_wdata | input | 32 | Word to preload |
| dbg_reg_sel | input | 5 | Register number for a debug read |
| dbg_reg_data | output | 32 | Contents of the selected register |
| dbg_mem_addr | input | 6 | Data word index for a debug read |
| dbg_mem_data | output | 32 | Contents of the selected data word |
| pc_out | output | 32 | Current program counter (byte address) |

## Verification
The properties assume that every word the PC can reach has been preloaded before reset is released, and that instruction memory is not rewritten while the program runs. Under those conditions the fetched instruction is always defined, and PC steps and branch targets can be predicted from it. They also assume that computed data addresses are word-aligned and fall inside the array. The bench therefore fills instruction memory and all of data memory during reset. Its program uses only aligned in-range offsets, including a negative one. It ends in a self-branch, so the PC settles at a known address before any state is read back.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADDU   = 6'h21;
    localparam logic [5:0] FN_SUBU   = 6'h23;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_OR
    } alu_op_e;

    typedef enum logic [2:0] {
        K_NOP,
        K_ADDU,
        K_SUBU,
        K_ORI,
        K_LW,
        K_SW,
        K_BEQ
    } kind_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_is_rd;
        logic    use_imm;
        logic    zext_imm;
        alu_op_e alu_op;
        logic    mem_we;
        logic    load_sel;
        logic    branch;
    } ctrl_t;

endpackage

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_d,
    input  logic [AW-1:0] wa,
    input  logic          we,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_d
);

    logic [W-1:0] regs [N];

    // Entry 0 is cleared by reset and never written afterwards.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_d = regs[ra_d];

endmodule

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [4:0] shamt,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    kind_e kind;

    always_comb begin
        kind = K_NOP;
        unique case (opcode)
            OPC_RTYPE: begin
                if (shamt == 5'd0 && funct == FN_ADDU)      kind = K_ADDU;
                else if (shamt == 5'd0 && funct == FN_SUBU) kind = K_SUBU;
                else                                        kind = K_NOP;
            end
            OPC_ORI: kind = K_ORI;
            OPC_LW:  kind = K_LW;
            OPC_SW:  kind = K_SW;
            OPC_BEQ: kind = K_BEQ;
            default: kind = K_NOP;
        endcase
    end

    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_is_rd: 1'b0, use_imm: 1'b0, zext_imm: 1'b0,
                 alu_op: ALU_ADD, mem_we: 1'b0, load_sel: 1'b0, branch: 1'b0};
        unique case (kind)
            K_ADDU: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
            end
            K_SUBU: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            K_ORI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.use_imm  = 1'b1;
                ctrl.zext_imm = 1'b1;
                ctrl.alu_op   = ALU_OR;
            end
            K_LW: begin
                ctrl.reg_we   = 1'b1;
                ctrl.use_imm  = 1'b1;
                ctrl.load_sel = 1'b1;
            end
            K_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            K_BEQ: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.branch = 1'b1;
            end
            K_NOP: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NREGS      = 32,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IA_W = $clog2(IMEM_WORDS),
    localparam int DA_W = $clog2(DMEM_WORDS),
    localparam int RA_W = $clog2(NREGS),
    localparam int LD_W = (IA_W > DA_W) ? IA_W : DA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_imem_we,
    input  logic            ld_dmem_we,
    input  logic [LD_W-1:0] ld_addr,
    input  logic [XLEN-1:0] ld_wdata,
    input  logic [RA_W-1:0] dbg_reg_sel,
    output logic [XLEN-1:0] dbg_reg_data,
    input  logic [DA_W-1:0] dbg_mem_addr,
    output logic [XLEN-1:0] dbg_mem_data,
    output logic [XLEN-1:0] pc_out
);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_plus4, br_target, pc_next;
    logic [31:0]     instr;
    logic [15:0]     imm16;
    logic [XLEN-1:0] ext_imm, rd_a, rd_b, alu_b, alu_y, mem_rdata, wr_data;
    logic [RA_W-1:0] wr_addr;
    logic [DA_W-1:0] mem_idx;
    logic            alu_zero, core_dmem_we;
    ctrl_t           ctrl;

    // Fetch
    assign instr = imem[pc_q[IA_W+1:2]];
    assign imm16 = instr[15:0];

    sc_decoder u_dec (
        .opcode (instr[31:26]),
        .shamt  (instr[10:6]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    assign wr_addr = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
    assign wr_data = ctrl.load_sel ? mem_rdata : alu_y;

    sc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (instr[25:21]),
        .ra_b (instr[20:16]),
        .ra_d (dbg_reg_sel),
        .wa   (wr_addr),
        .we   (ctrl.reg_we),
        .wd   (wr_data),
        .rd_a (rd_a),
        .rd_b (rd_b),
        .rd_d (dbg_reg_data)
    );

    // Execute
    assign ext_imm = ctrl.zext_imm ? {{(XLEN-16){1'b0}}, imm16}
                                   : {{(XLEN-16){imm16[15]}}, imm16};
    assign alu_b   = ctrl.use_imm ? ext_imm : rd_b;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rd_a),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Memory
    assign mem_idx      = alu_y[DA_W+1:2];
    assign mem_rdata    = dmem[mem_idx];
    assign core_dmem_we = ctrl.mem_we && !rst;
    assign dbg_mem_data = dmem[dbg_mem_addr];

    always_ff @(posedge clk) begin
        if (ld_dmem_we)        dmem[ld_addr[DA_W-1:0]] <= ld_wdata;
        else if (core_dmem_we) dmem[mem_idx]           <= rd_b;
    end

    always_ff @(posedge clk) begin
        if (ld_imem_we) imem[ld_addr[IA_W-1:0]] <= ld_wdata;
    end

    // Next address
    assign pc_plus4  = pc_q + XLEN'(4);
    assign br_target = pc_plus4 + {ext_imm[XLEN-3:0], 2'b00};
    assign pc_next   = (ctrl.branch && alu_zero) ? br_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_out = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] instr,
    input logic [31:0] pc,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        dmem_we,
    input logic [4:0]  dbg_reg_sel,
    input logic [31:0] dbg_reg_data
);

    // R1: reset forces the PC to zero
    a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc == 32'd0);

    // R7: any non-branch instruction steps the PC by four
    a_r7_seq_pc: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] != 6'h04) |=> pc == $past(pc) + 32'd4);

    // R7: a branch on unequal operands falls through
    a_r7_beq_fall: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == 6'h04 && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

    // R6: a branch on equal operands jumps to the scaled offset
    a_r6_beq_taken: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == 6'h04 && rs_val == rt_val) |=>
        pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

    // R5: only the store opcode writes data memory
    a_r5_store_only: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> instr[31:26] == 6'h2B);

    // R8: register zero always reads zero
    a_r8_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (dbg_reg_sel == 5'd0) |-> dbg_reg_data == 32'd0);

endmodule

bind sc_core sc_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .instr        (instr),
    .pc           (pc_q),
    .rs_val       (rd_a),
    .rt_val       (rd_b),
    .dmem_we      (core_dmem_we),
    .dbg_reg_sel  (dbg_reg_sel),
    .dbg_reg_data (dbg_reg_data)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_wdata = '0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_data;
    logic [5:0]  dbg_mem_addr = '0;
    logic [31:0] dbg_mem_data;
    logic [31:0] pc_out;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sc_core u_dut (
        .clk(clk), .rst(rst),
        .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
        .ld_addr(ld_addr), .ld_wdata(ld_wdata),
        .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
        .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data),
        .pc_out(pc_out)
    );

    function automatic logic [31:0] enc_r(input int rs, rt, rd, sh, fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(input int op, rs, rt, input logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] prog(input int i);
        case (i)
            0:  return enc_i('h0D, 0, 1, 16'h0005);      // R3
            1:  return enc_i('h0D, 0, 2, 16'h8003);      // R3 zero extension
            2:  return enc_r(1, 2, 3, 0, 'h21);          // R2 addu
            3:  return enc_r(1, 2, 4, 0, 'h23);          // R2 subu wraps
            4:  return enc_i('h2B, 0, 3, 16'h0008);      // R5
            5:  return enc_i('h23, 0, 5, 16'h0008);      // R4
            6:  return enc_i('h0D, 0, 6, 16'h0010);
            7:  return enc_i('h23, 6, 7, 16'hFFFC);      // R4 negative offset
            8:  return enc_i('h04, 1, 2, 16'h0005);      // R7 not taken
            9:  return enc_i('h0D, 0, 8, 16'h0001);
            10: return enc_i('h04, 3, 5, 16'h0002);      // R6 taken to word 13
            11: return enc_i('h0D, 0, 9, 16'h0077);
            12: return enc_i('h0D, 0, 9, 16'h0077);
            13: return 32'hFC0A_FFFF;                    // R9 unknown opcode
            14: return enc_r(1, 1, 0, 0, 'h21);          // R8 write to r0
            15: return enc_i('h0D, 0, 10, 16'hABCD);
            16: return enc_i('h2B, 6, 4, 16'h0000);      // R5
            17: return enc_r(2, 1, 11, 1, 'h23);         // R9 nonzero shamt
            18: return enc_r(1, 2, 12, 0, 'h25);         // R9 unknown funct
            default: return enc_i('h04, 0, 0, 16'hFFFF); // self loop
        endcase
    endfunction

    // {kind(0 reg,1 mem,2 pc), index, expected, requirement}
    localparam logic [43:0] VEC [15] = '{
        {2'd0, 6'd1,  32'h0000_0005, 4'd3},
        {2'd0, 6'd2,  32'h0000_8003, 4'd3},
        {2'd0, 6'd3,  32'h0000_8008, 4'd2},
        {2'd0, 6'd4,  32'hFFFF_8002, 4'd2},
        {2'd1, 6'd2,  32'h0000_8008, 4'd5},
        {2'd0, 6'd5,  32'h0000_8008, 4'd4},
        {2'd0, 6'd7,  32'hCAFE_F00D, 4'd4},
        {2'd0, 6'd8,  32'h0000_0001, 4'd7},
        {2'd0, 6'd9,  32'h0000_0000, 4'd6},
        {2'd0, 6'd10, 32'h0000_ABCD, 4'd9},
        {2'd0, 6'd0,  32'h0000_0000, 4'd8},
        {2'd0, 6'd11, 32'h0000_0000, 4'd9},
        {2'd0, 6'd12, 32'h0000_0000, 4'd9},
        {2'd1, 6'd4,  32'hFFFF_8002, 4'd5},
        {2'd2, 6'd0,  32'd76,        4'd6}
    };

    task automatic check(input string req, input logic [31:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input int idx, output logic [31:0] v);
        dbg_reg_sel = 5'(idx);
        #1 v = dbg_reg_data;
    endtask

    task automatic rd_mem(input int idx, output logic [31:0] v);
        dbg_mem_addr = 6'(idx);
        #1 v = dbg_mem_data;
    endtask

    task automatic preload(input logic imem_sel, input int idx, input logic [31:0] w);
        @(negedge clk);
        ld_imem_we = imem_sel;
        ld_dmem_we = !imem_sel;
        ld_addr    = 6'(idx);
        ld_wdata   = w;
        @(negedge clk);
        ld_imem_we = 1'b0;
        ld_dmem_we = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        all_zero;
        repeat (2) @(posedge clk);
        for (int i = 0; i < 64; i++) preload(1'b1, i, prog(i));
        for (int i = 0; i < 64; i++) preload(1'b0, i, (i == 3) ? 32'hCAFE_F00D : 32'h0);

        // R1: reset state
        check("R1 pc", pc_out, 32'h0);
        all_zero = 1'b1;
        for (int i = 0; i < 32; i++) begin
            rd_reg(i, v);
            if (v !== 32'h0) all_zero = 1'b0;
        end
        check("R1 regs clear", {31'h0, all_zero}, 32'h1);

        @(negedge clk);
        rst = 1'b0;
        repeat (30) @(posedge clk);
        @(negedge clk);

        for (int k = 0; k < 15; k++) begin
            logic [43:0] e;
            string       tag;
            e   = VEC[k];
            tag = $sformatf("R%0d vec%0d", e[3:0], k);
            case (e[43:42])
                2'd0:    rd_reg(int'(e[41:36]), v);
                2'd1:    rd_mem(int'(e[41:36]), v);
                default: v = pc_out;
            endcase
            check(tag, v, e[35:4]);
        end

        // R10: preload while running, debug read leaves the PC alone
        preload(1'b0, 10, 32'h1234_5678);
        rd_mem(10, v);
        check("R10 preload dmem", v, 32'h1234_5678);
        check("R10 pc undisturbed", pc_out, 32'd76);

        // R1: reset in mid-run clears state and restarts
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 pc after rerst", pc_out, 32'h0);
        rd_reg(1, v);
        check("R1 r1 cleared", v, 32'h0);
        rd_reg(10, v);
        check("R1 r10 cleared", v, 32'h0);
        rd_mem(4, v);
        check("R1 dmem kept", v, 32'hFFFF_8002);
        rst = 1'b0;
        repeat (30) @(posedge clk);
        @(negedge clk);
        rd_reg(3, v);
        check("R2 rerun addu", v, 32'h0000_8008);
        check("R6 rerun pc", pc_out, 32'd76);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule